// File: doc/BRIEF.md
# Systolic Array Microcode Sequencer

This block turns one packed 48-bit matrix instruction into the cycle-by-cycle control strobes of an N x N systolic multiply array. A caller presents an instruction word with a valid/ready handshake. Once it is accepted, the sequencer runs its own phase counter and derives every lane enable from comparisons against that counter. Each comparison is gated by the column or row mask carried in the instruction. No stored microcode table is used, so the logic grows linearly with N.

Two operations do work. A weight load pops the weight FIFO on every cycle of its phase and fires one capture enable per column along a diagonal wavefront. A compute operation opens staggered read windows on the rows of the activation buffer. It then opens accumulator valid windows on the columns, with the same stagger, once data has crossed the array. A repeat count runs the phase several times back to back. A done pulse marks the last cycle of the instruction.

Top module: `sa_ucode_seq`

## Requirements
- R1: The instruction word is read with opcode in bits 47:44, repeat count in bits 39:32, column mask in bits 31:24 and row mask in bits 23:16. Bits 43:40 and 15:0 have no effect. Opcode 4'h1 is weight load and 4'h2 is compute.
- R2: `instr_ready` is high exactly when the sequencer is idle. A word is accepted on a clock edge where `instr_valid` and `instr_ready` are both high. A valid word presented while busy has no effect.
- R3: A weight-load phase lasts N+1 cycles, numbered 0..N from acceptance, and `wfifo_pop` is high on every one of them.
- R4: In a weight-load phase, `col_capture[i]` is high only in phase cycle i+1, and only when column mask bit i is set.
- R5: A compute phase lasts 3N-1 cycles, numbered 0..3N-2. `row_read[i]` is high in phase cycles i+1 through N+i-1 when row mask bit i is set.
- R6: In a compute phase, `acc_valid[i]` is high in phase cycles N+1+i through 2N+i-1 when column mask bit i is set.
- R7: The phase repeats back to back, restarting at cycle 0, as many times as the count field says. A count of 0 runs it once.
- R8: `done` is a single-cycle pulse on the final cycle of the final repetition. In the next cycle the sequencer is idle.
- R9: Mask bits at positions N and above have no effect on any output.
- R10: A synchronous active-high reset makes the block idle with `instr_ready` high and every strobe low. This holds even in the middle of an instruction.
- R11: Any opcode other than 4'h1 or 4'h2 occupies one busy cycle per repetition, with `done` on the last one and no strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 48 | Packed instruction |
| instr_ready | output | 1 | Sequencer idle, can accept |
| busy | output | 1 | An instruction is running |
| done | output | 1 | Final cycle of the running instruction |
| wfifo_pop | output | 1 | Weight FIFO pop strobe |
| col_capture | output | N | Per-column weight capture enables |
| row_read | output | N | Per-row activation buffer read enables |
| acc_valid | output | N | Per-column accumulator valid strobes |

## Verification
In a compute phase the late row read windows and the early accumulator windows coincide. With N=4, row 3 reads through cycle 6 while column 0 becomes valid at cycle 5. The final accumulator strobe also lands in the same cycle as `done`. The bench drives compute instructions with full and partial masks so that these overlaps occur. It counts the cycles where row reads and accumulator strobes are both active and requires that count to be non-zero. Every strobe in those cycles is compared against a behavioural model that computes each window from the requirement formulas.

// File: rtl/sa_seq_pkg.sv
package sa_seq_pkg;

   localparam int INSTR_W = 48;

   localparam logic [3:0] OPC_WLOAD = 4'h1;
   localparam logic [3:0] OPC_CMPT  = 4'h2;

   typedef struct packed {
      logic [3:0] opcode;
      logic [3:0] flags;
      logic [7:0] count;
      logic [7:0] col_mask;
      logic [7:0] row_mask;
      logic [7:0] addr;
      logic [7:0] cond;
   } instr_t;

   function automatic logic [7:0] reps_left_init(input logic [7:0] cnt);
      return (cnt == 8'd0) ? 8'd0 : cnt - 8'd1;
   endfunction

endpackage

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
   import sa_seq_pkg::*;
#(
   parameter int N  = 4,
   parameter int CW = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                instr_valid,
   input  logic [INSTR_W-1:0]  instr_word,
   output logic                instr_ready,
   output logic                busy,
   output logic                done,
   output logic                load_act,
   output logic                cmpt_act,
   output logic [CW-1:0]       cnt,
   output logic [N-1:0]        col_mask,
   output logic [N-1:0]        row_mask
);

   localparam int LOAD_LAST = N;
   localparam int CMPT_LAST = 3 * N - 2;

   instr_t          iw;
   logic            busy_q;
   logic [3:0]      op_q;
   logic [CW-1:0]   cnt_q;
   logic [7:0]      reps_q;
   logic [N-1:0]    cm_q;
   logic [N-1:0]    rm_q;
   logic [CW-1:0]   last_cnt;
   logic            accept;
   logic            at_last;

   assign iw = instr_t'(instr_word);

   // Fields that carry no meaning for sequencing, plus mask bits beyond N.
   logic unused_fields;
   generate
      if (N < 8) begin : g_hi_unused
         assign unused_fields = ^{iw.flags, iw.addr, iw.cond,
                                  iw.col_mask[7:N], iw.row_mask[7:N]};
      end else begin : g_hi_none
         assign unused_fields = ^{iw.flags, iw.addr, iw.cond};
      end
   endgenerate

   always_comb begin
      case (op_q)
         OPC_WLOAD: last_cnt = CW'(LOAD_LAST);
         OPC_CMPT:  last_cnt = CW'(CMPT_LAST);
         default:   last_cnt = '0;
      endcase
   end

   assign accept  = instr_valid && !busy_q;
   assign at_last = busy_q && (cnt_q == last_cnt);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         op_q   <= 4'h0;
         cnt_q  <= '0;
         reps_q <= 8'd0;
         cm_q   <= '0;
         rm_q   <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         op_q   <= iw.opcode;
         cnt_q  <= '0;
         reps_q <= reps_left_init(iw.count);
         cm_q   <= iw.col_mask[N-1:0];
         rm_q   <= iw.row_mask[N-1:0];
      end else if (busy_q) begin
         if (at_last) begin
            if (reps_q == 8'd0) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               reps_q <= reps_q - 8'd1;
               cnt_q  <= '0;
            end
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign instr_ready = !busy_q;
   assign busy        = busy_q;
   assign done        = at_last && (reps_q == 8'd0);
   assign load_act    = busy_q && (op_q == OPC_WLOAD);
   assign cmpt_act    = busy_q && (op_q == OPC_CMPT);
   assign cnt         = cnt_q;
   assign col_mask    = cm_q;
   assign row_mask    = rm_q;

   p_accept_starts_r2: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_ready) |=> (busy && cnt == '0));

   p_done_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);

   p_cnt_in_phase_r7: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt <= CW'(CMPT_LAST)));

endmodule

// File: rtl/sa_stagger_lanes.sv
module sa_stagger_lanes #(
   parameter int N    = 4,
   parameter int CW   = 4,
   parameter int BASE = 1,
   parameter int SPAN = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          act,
   input  logic [CW-1:0] cnt,
   input  logic [N-1:0]  mask,
   output logic [N-1:0]  en
);

   generate
      if (SPAN < 1) begin : g_bad_span
         $error("sa_stagger_lanes: SPAN must be at least 1");
      end
      if (BASE + N + SPAN - 2 >= (1 << CW)) begin : g_bad_cw
         $error("sa_stagger_lanes: counter too narrow for lane windows");
      end

      for (genvar i = 0; i < N; i++) begin : g_lane
         localparam int LO = BASE + i;
         localparam int HI = BASE + i + SPAN - 1;
         if (SPAN == 1) begin : g_point
            assign en[i] = act && mask[i] && (cnt == CW'(LO));
         end else begin : g_window
            assign en[i] = act && mask[i] && (cnt >= CW'(LO)) && (cnt <= CW'(HI));
         end
      end
   endgenerate

   p_lane_needs_phase_r9: assert property (@(posedge clk) disable iff (rst)
      (|en) |-> act);

endmodule

// File: rtl/sa_ucode_seq.sv
module sa_ucode_seq
   import sa_seq_pkg::*;
#(
   parameter int N = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   output logic               instr_ready,
   output logic               busy,
   output logic               done,
   output logic               wfifo_pop,
   output logic [N-1:0]       col_capture,
   output logic [N-1:0]       row_read,
   output logic [N-1:0]       acc_valid
);

   localparam int CW = $clog2(3 * N);

   generate
      if (N < 2 || N > 8) begin : g_bad_n
         $error("sa_ucode_seq: N must lie in 2..8 to fit the 8-bit masks");
      end
   endgenerate

   logic          load_act;
   logic          cmpt_act;
   logic [CW-1:0] cnt;
   logic [N-1:0]  cm;
   logic [N-1:0]  rm;

   sa_seq_ctrl #(.N(N), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .instr_ready (instr_ready),
      .busy        (busy),
      .done        (done),
      .load_act    (load_act),
      .cmpt_act    (cmpt_act),
      .cnt         (cnt),
      .col_mask    (cm),
      .row_mask    (rm)
   );

   // Column capture: a single cycle per column, diagonal wavefront.
   sa_stagger_lanes #(.N(N), .CW(CW), .BASE(1), .SPAN(1)) u_cap (
      .clk (clk), .rst (rst), .act (load_act), .cnt (cnt), .mask (cm), .en (col_capture)
   );

   // Row reads: row i open for cycles i+1 .. N+i-1.
   sa_stagger_lanes #(.N(N), .CW(CW), .BASE(1), .SPAN(N - 1)) u_rows (
      .clk (clk), .rst (rst), .act (cmpt_act), .cnt (cnt), .mask (rm), .en (row_read)
   );

   // Accumulator strobes: same stagger, shifted by the array depth.
   sa_stagger_lanes #(.N(N), .CW(CW), .BASE(N + 1), .SPAN(N - 1)) u_acc (
      .clk (clk), .rst (rst), .act (cmpt_act), .cnt (cnt), .mask (cm), .en (acc_valid)
   );

   assign wfifo_pop = load_act;

   p_pop_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
      wfifo_pop |-> busy);

   p_capture_single_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col_capture));

   p_phases_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
      (|row_read) |-> (!wfifo_pop && col_capture == '0));

endmodule

// File: tb/tb_sa_ucode_seq.sv
module tb_sa_ucode_seq;

   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          instr_valid = 1'b0;
   logic [47:0]   instr_word = '0;
   logic          instr_ready, busy, done, wfifo_pop;
   logic [N-1:0]  col_capture, row_read, acc_valid;

   always #5 clk = ~clk;

   sa_ucode_seq #(.N(N)) dut (
      .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr_word (instr_word),
      .instr_ready (instr_ready), .busy (busy), .done (done), .wfifo_pop (wfifo_pop),
      .col_capture (col_capture), .row_read (row_read), .acc_valid (acc_valid)
   );

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int overlap = 0;

   // Behavioural reference state
   bit          m_busy = 0;
   int          m_k = 0;
   int          m_rep = 0;
   int          m_op = 0;
   bit [7:0]    m_cm = 0;
   bit [7:0]    m_rm = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int last_of(input int op);
      if (op == 1) return N;
      if (op == 2) return 3 * N - 2;
      return 0;
   endfunction

   function automatic logic [47:0] mk(input int op, input int cnt, input int cm, input int rm);
      // R1: opcode 47:44, flags 43:40, count 39:32, cmask 31:24, rmask 23:16
      return {op[3:0], 4'hA, cnt[7:0], cm[7:0], rm[7:0], 16'h5A3C};
   endfunction

   always @(negedge clk) begin
      bit            e_pop, e_done;
      logic [N-1:0]  e_col, e_row, e_acc;
      int            lst;
      cycles++;
      lst = last_of(m_op);
      e_pop  = m_busy && m_op == 1;
      e_done = m_busy && m_k == lst && m_rep == 0;
      for (int i = 0; i < N; i++) begin
         e_col[i] = m_busy && m_op == 1 && m_k == i + 1 && m_cm[i];
         e_row[i] = m_busy && m_op == 2 && m_k >= i + 1 && m_k <= N + i - 1 && m_rm[i];
         e_acc[i] = m_busy && m_op == 2 && m_k >= N + 1 + i && m_k <= 2 * N + i - 1 && m_cm[i];
      end
      chk(instr_ready === !m_busy, "R2 ready", instr_ready, !m_busy);
      chk(busy === m_busy, "R2 busy", busy, m_busy);
      chk(wfifo_pop === e_pop, "R3 pop", wfifo_pop, e_pop);
      chk(col_capture === e_col, "R4 col_capture", col_capture, e_col);
      chk(row_read === e_row, "R5 row_read", row_read, e_row);
      chk(acc_valid === e_acc, "R6 acc_valid", acc_valid, e_acc);
      chk(done === e_done, "R8 done", done, e_done);
      if (row_read != 0 && acc_valid != 0) overlap++;

      // advance model over the coming edge
      if (rst) begin
         m_busy = 0; m_k = 0; m_rep = 0; m_op = 0;
      end else if (!m_busy && instr_valid) begin
         m_busy = 1; m_k = 0;
         m_op  = int'(instr_word[47:44]);
         m_rep = (instr_word[39:32] == 0) ? 0 : int'(instr_word[39:32]) - 1;
         m_cm  = instr_word[31:24];
         m_rm  = instr_word[23:16];
      end else if (m_busy) begin
         if (m_k == lst) begin
            if (m_rep == 0) m_busy = 0;
            else begin m_rep--; m_k = 0; end
         end else m_k++;
      end

      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // Issue one instruction, then measure its busy length (R1, R7, R11).
   task automatic run(input int op, input int cnt, input int cm, input int rm, input string req);
      int exp_len, len, reps;
      reps = (cnt == 0) ? 1 : cnt;
      exp_len = reps * (last_of(op) + 1);
      @(posedge clk); #1;
      instr_valid = 1'b1;
      instr_word  = mk(op, cnt, cm, rm);
      @(posedge clk); #1;
      instr_valid = 1'b0;
      len = 0;
      forever begin
         @(negedge clk);
         if (!busy) break;
         len++;
      end
      chk(len == exp_len, req, len, exp_len);
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      chk(instr_ready && !busy && !done && !wfifo_pop && col_capture == 0 &&
          row_read == 0 && acc_valid == 0, "R10 reset idle", busy, 0);
      @(posedge clk); #1 rst = 1'b0;

      run(1, 1, 8'hFF, 8'h00, "R3 load length");
      run(1, 0, 8'h0F, 8'h00, "R7 count zero runs once");
      run(1, 3, 8'h05, 8'h00, "R7 load repeated x3");
      run(2, 1, 8'h0F, 8'h0F, "R5 compute length");
      run(2, 2, 8'h09, 8'h06, "R7 compute repeated x2 partial masks");
      run(7, 1, 8'hFF, 8'hFF, "R11 other opcode one cycle");
      run(0, 3, 8'hFF, 8'hFF, "R11 opcode zero repeated");
      run(1, 1, 8'hF0, 8'hF0, "R9 high mask bits ignored load");
      run(2, 1, 8'hF0, 8'hF0, "R9 high mask bits ignored compute");
      run(2, 1, 8'hAF, 8'h5F, "R9 mixed high bits");

      // R2: valid held while busy with another word is ignored, then
      // accepted right after the first instruction finishes.
      @(posedge clk); #1;
      instr_valid = 1'b1;
      instr_word  = mk(2, 1, 8'h0F, 8'h0F);
      @(posedge clk); #1;
      instr_word  = mk(1, 1, 8'h0F, 8'h00);
      while (!instr_ready) @(posedge clk);
      @(posedge clk); #1;
      instr_valid = 1'b0;
      repeat (12) @(posedge clk);

      // R10: reset in the middle of a compute instruction
      @(posedge clk); #1;
      instr_valid = 1'b1;
      instr_word  = mk(2, 4, 8'h0F, 8'h0F);
      @(posedge clk); #1;
      instr_valid = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      chk(instr_ready && !busy && row_read == 0 && acc_valid == 0, "R10 mid-run reset",
          busy, 0);
      repeat (3) @(posedge clk);

      // R5/R6: row reads and accumulator strobes must have shared cycles
      chk(overlap > 0, "R6 row/acc overlap seen", overlap, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule